// File: doc/BRIEF.md
# Pin Bank with Rising-Edge Interrupts

This block is a bank of eight general-purpose pins for one port. Each pin can be an input or an output, chosen per pin. The two highest pins, 6 and 7, use open-drain drivers. Pins 0 to 5 use tri-state drivers. A small register interface lets software set the direction, the output value and the detection enables. Software can also read the pin levels and the interrupt cause.

After reset, no pin drives. The pins stay inputs until a configuration-load pulse arrives. That pulse applies each pin's power-up direction and initial output value. A pin with no loaded setting becomes an output that drives 0.

Pins 0 to 3 can raise an interrupt. The bank samples each pad on a sampling tick, after a two-flop synchronizer. When a pin is an input and its detection enable is set, a 0 sample followed by a 1 sample sets that pin's sticky cause bit. The interrupt output is the OR of the cause bits.

Top module: `gpio_bank`

## Requirements
- R1: From reset until the first `cfg_load` pulse, `pad_oe` is all zeros, whatever software writes.
- R2: On `cfg_load`, each pin with `cfg_have[i]=1` takes its direction from `cfg_dir[i]` (1 = output) and its value from `cfg_val[i]`. A pin with `cfg_have[i]=0` becomes an output with value 0.
- R3: Pins 6 and 7 are open-drain: `pad_out` is always 0 there. When such a pin is an output, `pad_oe` is 1 only while its value is 0.
- R4: Pins 0 to 5 are tri-state: `pad_oe[i]` equals the pin's direction bit and `pad_out[i]` equals its value bit.
- R5: Register writes to the direction address (0) and the value address (1) have no effect before the configuration has loaded. Writes to the detection-enable address (2) are accepted at any time.
- R6: A pin 0 to 3 sets its cause bit when all of these hold: the pin is an input, its enable bit at address 2 is set, and on a `sample_tick` cycle its synchronized level is 1 after the previous tick's sample was 0.
- R7: No cause bit is set without a tick, while the enable bit is clear, or while the pin is an output. Pins 4 to 7 never raise an interrupt.
- R8: A pad that is already high when reset is released gives no edge on the first ticks, even with detection enabled.
- R9: Cause bits (address 3, bits 0 to 3) are sticky and clear when software writes a 1 to them. An edge in the same cycle as the clear leaves the bit set.
- R10: `irq` is 1 exactly when at least one cause bit is set.
- R11: A read of address 4 returns the synchronized pad level for input pins and the driven value for output pins.
- R12: A falling edge (a 1 sample followed by a 0 sample) never sets a cause bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | One-cycle pulse that applies the power-up configuration |
| cfg_have | input | 8 | Per pin: the loaded word carries a setting |
| cfg_dir | input | 8 | Loaded direction, 1 = output |
| cfg_val | input | 8 | Loaded initial output value |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 dir, 1 value, 2 enable, 3 cause, 4 level |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| sample_tick | input | 1 | Sampling enable for edge detection |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output data |
| pad_oe | output | 8 | Pad output enable |
| irq | output | 1 | OR of the cause bits |

## Verification
The assertions check four rules on every cycle: nothing drives before the load, the open-drain pins never drive high, cause bits fall only on a software clear, and direction and value stay frozen before the load. They also check that a cause bit set by an edge holds through a clear in the same cycle, and that `irq` rises only after a tick. Some behaviour can only be shown by the bench's scenarios, because it depends on when the pads change relative to the ticks. These are the settle period that suppresses a false edge at reset, the cases of falling edges, pins set as outputs and disabled pins, and the readback mix of pad levels and driven values.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_DIR   = 3'd0,
        ADDR_VAL   = 3'd1,
        ADDR_DETEN = 3'd2,
        ADDR_CAUSE = 3'd3,
        ADDR_LEVEL = 3'd4
    } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int W           = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] level,
    input  logic [W-1:0] enable,
    input  logic [W-1:0] is_input,
    output logic [W-1:0] edge_o
);
    localparam int CW = $clog2(SYNC_STAGES + 1);

    typedef struct packed {
        logic [W-1:0]  prev;
        logic          primed;
        logic [CW-1:0] settle;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       settled;

    always_comb begin
        st_d    = st_q;
        settled = (st_q.settle == CW'(SYNC_STAGES));
        if (!settled) st_d.settle = st_q.settle + 1'b1;
        if (tick && settled) begin
            st_d.prev   = level;
            st_d.primed = 1'b1;
        end
        edge_o = {W{tick & st_q.primed}} & level & ~st_q.prev & enable & is_input;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    primed_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.primed) |-> $past(tick));
endmodule

// File: rtl/gpio_cause.sv
module gpio_cause #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] cause_o
);
    logic [W-1:0] cause_d, cause_q;

    always_comb begin
        cause_d = (cause_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

    assign cause_o = cause_q;

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R9
        sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cause_q[i]) |-> $past(clr_i[i]));
        // R9
        set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> cause_q[i]);
    end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int N        = 8,
    parameter int OD_FIRST = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         loaded,
    input  logic [N-1:0] dir,
    input  logic [N-1:0] val,
    output logic [N-1:0] pad_out,
    output logic [N-1:0] pad_oe
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        if (i >= OD_FIRST) begin : g_od
            assign pad_out[i] = 1'b0;
            assign pad_oe[i]  = loaded & dir[i] & ~val[i];
            // R3
            od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(pad_oe[i] && pad_out[i]));
        end else begin : g_tri
            assign pad_out[i] = val[i];
            assign pad_oe[i]  = loaded & dir[i];
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
    parameter int NUM_PINS    = 8,
    parameter int OD_FIRST    = 6,
    parameter int IRQ_PINS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_load,
    input  logic [NUM_PINS-1:0]         cfg_have,
    input  logic [NUM_PINS-1:0]         cfg_dir,
    input  logic [NUM_PINS-1:0]         cfg_val,
    input  logic                        reg_we,
    input  logic [gpio_pkg::ADDR_W-1:0] reg_addr,
    input  logic [NUM_PINS-1:0]         reg_wdata,
    output logic [NUM_PINS-1:0]         reg_rdata,
    input  logic                        sample_tick,
    input  logic [NUM_PINS-1:0]         pad_in,
    output logic [NUM_PINS-1:0]         pad_out,
    output logic [NUM_PINS-1:0]         pad_oe,
    output logic                        irq
);
    import gpio_pkg::*;

    localparam int PAD_W = NUM_PINS - IRQ_PINS;

    typedef struct packed {
        logic                loaded;
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] val;
        logic [IRQ_PINS-1:0] deten;
    } bank_state_t;

    bank_state_t         st_d, st_q;
    logic [NUM_PINS-1:0] level_sync;
    logic [NUM_PINS-1:0] eff_dir;
    logic [NUM_PINS-1:0] pin_view;
    logic [IRQ_PINS-1:0] edge_hit;
    logic [IRQ_PINS-1:0] cause_clr;
    logic [IRQ_PINS-1:0] cause;

    always_comb begin
        st_d      = st_q;
        cause_clr = '0;
        if (cfg_load) begin
            st_d.loaded = 1'b1;
            st_d.dir    = cfg_dir | ~cfg_have;
            st_d.val    = cfg_val & cfg_have;
        end else if (reg_we) begin
            case (reg_addr)
                ADDR_DIR:   if (st_q.loaded) st_d.dir = reg_wdata;
                ADDR_VAL:   if (st_q.loaded) st_d.val = reg_wdata;
                ADDR_DETEN: st_d.deten = reg_wdata[IRQ_PINS-1:0];
                default:    ;
            endcase
        end
        if (reg_we && reg_addr == ADDR_CAUSE) cause_clr = reg_wdata[IRQ_PINS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (level_sync)
    );

    assign eff_dir  = st_q.dir & {NUM_PINS{st_q.loaded}};
    assign pin_view = (eff_dir & st_q.val) | (~eff_dir & level_sync);

    gpio_edge_detect #(.W(IRQ_PINS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sample_tick),
        .level   (level_sync[IRQ_PINS-1:0]),
        .enable  (st_q.deten),
        .is_input(~eff_dir[IRQ_PINS-1:0]),
        .edge_o  (edge_hit)
    );

    gpio_cause #(.W(IRQ_PINS)) u_cause (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (edge_hit),
        .clr_i  (cause_clr),
        .cause_o(cause)
    );

    gpio_pad_drive #(.N(NUM_PINS), .OD_FIRST(OD_FIRST)) u_pads (
        .clk    (clk),
        .rst_n  (rst_n),
        .loaded (st_q.loaded),
        .dir    (st_q.dir),
        .val    (st_q.val),
        .pad_out(pad_out),
        .pad_oe (pad_oe)
    );

    assign irq = |cause;

    always_comb begin
        case (reg_addr)
            ADDR_DIR:   reg_rdata = st_q.dir;
            ADDR_VAL:   reg_rdata = st_q.val;
            ADDR_DETEN: reg_rdata = {{PAD_W{1'b0}}, st_q.deten};
            ADDR_CAUSE: reg_rdata = {{PAD_W{1'b0}}, cause};
            ADDR_LEVEL: reg_rdata = pin_view;
            default:    reg_rdata = '0;
        endcase
    end

    // R1
    quiet_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.loaded |-> (pad_oe == '0));
    // R5
    frozen_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.loaded && !cfg_load) |=> ($stable(st_q.dir) && $stable(st_q.val)));
    // R10
    irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(sample_tick));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [7:0] cfg_have = '0, cfg_dir = '0, cfg_val = '0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sample_tick = 1'b0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gpio_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_have(cfg_have),
        .cfg_dir(cfg_dir), .cfg_val(cfg_val), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sample_tick(sample_tick),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic set_pads(input logic [7:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_and_false_edge();
        logic [7:0] d;
        chk(pad_oe, 8'h00, "R1 reset oe");
        chk({7'd0, irq}, 8'h00, "R10 reset irq");
        wr(3'd2, 8'h0F);
        repeat (3) tick();
        rd(3'd3, d);
        chk(d, 8'h00, "R8 no false edge after reset");
        set_pads(8'h00);
        tick();
    endtask

    task automatic t_preload_writes();
        logic [7:0] d;
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        rd(3'd0, d);
        chk(d, 8'h00, "R5 dir write ignored");
        rd(3'd1, d);
        chk(d, 8'h00, "R5 val write ignored");
        chk(pad_oe, 8'h00, "R1 no drive before load");
    endtask

    task automatic t_load();
        logic [7:0] d;
        @(negedge clk);
        cfg_have = 8'hF3; cfg_dir = 8'hF0; cfg_val = 8'h50; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        rd(3'd0, d);
        chk(d, 8'hFC, "R2 loaded direction");
        rd(3'd1, d);
        chk(d, 8'h50, "R2 loaded value");
        chk(pad_oe, 8'hBC, "R3 R4 oe after load");
        chk(pad_out, 8'h10, "R3 R4 out after load");
    endtask

    task automatic t_level_read();
        logic [7:0] d;
        set_pads(8'h03);
        rd(3'd4, d);
        chk(d, 8'h53, "R11 level readback");
        set_pads(8'h00);
        tick();
    endtask

    task automatic t_edge_and_clear();
        logic [7:0] d;
        wr(3'd0, 8'hF0);
        set_pads(8'h01);
        tick();
        rd(3'd3, d);
        chk(d, 8'h01, "R6 rising edge sets cause");
        chk({7'd0, irq}, 8'h01, "R10 irq set");
        wr(3'd3, 8'h01);
        rd(3'd3, d);
        chk(d, 8'h00, "R9 write one clears");
        chk({7'd0, irq}, 8'h00, "R10 irq clear");
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        set_pads(8'h03);
        tick();
        set_pads(8'h01);
        tick();
        set_pads(8'h03);
        @(negedge clk);
        sample_tick = 1'b1; reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h02;
        @(negedge clk);
        sample_tick = 1'b0; reg_we = 1'b0;
        rd(3'd3, d);
        chk(d, 8'h02, "R9 set beats clear");
        wr(3'd3, 8'h0F);
    endtask

    task automatic t_no_tick();
        logic [7:0] d;
        set_pads(8'h07);
        repeat (4) @(negedge clk);
        rd(3'd3, d);
        chk(d, 8'h00, "R7 no tick no edge");
        tick();
        rd(3'd3, d);
        chk(d, 8'h04, "R6 edge seen on later tick");
        wr(3'd3, 8'h0F);
    endtask

    task automatic t_disabled_and_output();
        logic [7:0] d;
        wr(3'd2, 8'h07);
        set_pads(8'h0F);
        tick();
        rd(3'd3, d);
        chk(d, 8'h00, "R7 disabled pin ignored");
        wr(3'd2, 8'h0F);
        wr(3'd0, 8'hF1);
        set_pads(8'h0E);
        tick();
        set_pads(8'h0F);
        tick();
        rd(3'd3, d);
        chk(d, 8'h00, "R7 output pin ignored");
        wr(3'd0, 8'hF0);
    endtask

    task automatic t_upper_and_fall();
        logic [7:0] d;
        wr(3'd0, 8'h00);
        wr(3'd2, 8'hFF);
        set_pads(8'h0F);
        tick();
        set_pads(8'hFF);
        tick();
        rd(3'd3, d);
        chk(d, 8'h00, "R7 pins 4-7 never interrupt");
        set_pads(8'hF0);
        tick();
        rd(3'd3, d);
        chk(d, 8'h00, "R12 falling edge ignored");
    endtask

    task automatic t_open_drain();
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hC0);
        chk(pad_oe & 8'hC0, 8'h00, "R3 od release on one");
        wr(3'd1, 8'h00);
        chk(pad_oe & 8'hC0, 8'hC0, "R3 od pull low on zero");
        chk(pad_out & 8'hC0, 8'h00, "R3 od data zero");
        wr(3'd1, 8'h2A);
        chk(pad_out & 8'h3F, 8'h2A, "R4 tristate data");
        chk(pad_oe & 8'h3F, 8'h3F, "R4 tristate enable");
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        pad_in = 8'h0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_false_edge();
        t_preload_writes();
        t_load();
        t_level_read();
        t_edge_and_clear();
        t_set_wins();
        t_no_tick();
        t_disabled_and_output();
        t_upper_and_fall();
        t_open_drain();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule